// File: doc/BRIEF.md
# PHY Management Command Unit

This block lets a host manage a PHY register set through a few word-wide registers. The host writes a control word, a write-data word and a command word. The command word names a PHY address, a register address and an operation. When its start flag is set, the command completes in the same clock edge that accepts it. A write operation copies the low 16 bits of the write-data word into the addressed PHY register. A read operation copies the PHY register into the read-data word, and the host then fetches that word.

A behavioural PHY register model sits behind the unit at a parameter-defined 5-bit address. Most of its 32 registers hold whatever was last written. A few are built at read time from the advertisement register and from the `link_up` input. The serial management waveform is not modelled, and the unit is always ready for a new command.

The host port has no back-pressure. A write is taken on every clock edge where `host_wr` is high. A read is taken on every edge where `host_rd` is high, and `host_rdata` is valid with `host_rvalid` one cycle later. The host drives at most one of `host_wr` and `host_rd` in a cycle.

Top module: `mdio_mgmt_unit`

## Requirements
- R1: After reset the register reads are: control 0, command 0x80, write-data 0, read-data 0. The PHY registers read: 0 as 0x3100, 2 as 0x0300, 3 as 0xE400, 4 (advertisement) as 0x01E1. Register select codes are control 0, command 1, write-data 2, read-data 3.
- R2: A read on the host port returns data with `host_rvalid` high in the next cycle. The command word is decoded as PHY address 28:24, register 20:16, opcode 15:14 and start flag 11, and all other bits are ignored. A started opcode 2 loads the PHY register, zero-extended, into read-data at the edge that accepts the command.
- R3: A started opcode 1 writes bits 15:0 of write-data into the addressed PHY register at the edge that accepts the command.
- R4: A started command with opcode 0 or 3 pulses `op_err` high for the one cycle after it is accepted. It changes neither the PHY nor read-data. A command whose start flag is clear does nothing and raises no error.
- R5: A read aimed at a PHY address other than the configured one (default 7) returns 0xFFFF. A write aimed at such an address changes nothing.
- R6: A read of the command register returns the last written command word with bit 7 forced to 1.
- R7: A control write stores only bits 6:0 (bit 6 enable, bits 5:0 divisor). If the write sets the enable bit with a zero divisor, `div_err` pulses high for one cycle.
- R8: PHY register 1 reads 0x782E while `link_up` is 1 and 0 while it is 0.
- R9: PHY register 5 reads 0x4001 ORed with advertisement bits 8:5.
- R10: PHY register 17 reads 0x8000 whatever was written to it.
- R11: While the link is up, PHY register 18 has bit 10 set if advertisement bit 7 or 8 is set, and bit 11 set if advertisement bit 6 or 8 is set. All other bits are 0. While the link is down, register 18 reads 0.
- R12: After any PHY register write, bit 15 of PHY register 0 reads 0.
- R13: Every other PHY register returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select (0 control, 1 command, 2 write-data, 3 read-data) |
| host_wdata | input | HOST_W | Host write data |
| host_rdata | output | HOST_W | Read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| link_up | input | 1 | Link status given to the PHY model |
| op_err | output | 1 | One-cycle pulse: started command with an invalid opcode |
| div_err | output | 1 | One-cycle pulse: enabled with a zero clock divisor |

## Verification
Each PHY command takes effect at the same edge that accepts the command write. A read-data fetch issued in the following cycle therefore returns the new value with `host_rvalid` one cycle after the fetch, two edges after the command. The error pulses are high only in the cycle after the accepting edge. The driver therefore samples them at the falling edge straight after that write. The monitor compares returned words at the falling edge where `host_rvalid` is high, popping expected values in the order the driver queued them.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int PHY_AW  = 5;
  localparam int REG_AW  = 5;
  localparam int PHY_DW  = 16;
  localparam int PHY_NREG = 1 << REG_AW;

  // Command word field positions
  localparam int CMD_PHY_LSB = 24;
  localparam int CMD_REG_LSB = 16;
  localparam int CMD_OP_LSB  = 14;
  localparam int CMD_GO_BIT  = 11;
  localparam int CMD_RDY_BIT = 7;

  // Control word fields
  localparam int CTRL_W      = 7;
  localparam int CTRL_EN_BIT = 6;
  localparam int CTRL_DIV_W  = 6;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_WDAT = 2'd2,
    SEL_RDAT = 2'd3
  } host_sel_e;

  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  typedef struct packed {
    logic              go;
    logic [1:0]        op;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
  } mdio_cmd_t;

  // PHY register indices with special behaviour
  localparam int PREG_BASIC  = 0;
  localparam int PREG_STATUS = 1;
  localparam int PREG_ID_HI  = 2;
  localparam int PREG_ID_LO  = 3;
  localparam int PREG_ADV    = 4;
  localparam int PREG_LPA    = 5;
  localparam int PREG_SPEED  = 17;
  localparam int PREG_DIAG   = 18;

  localparam logic [PHY_DW-1:0] STATUS_LINK_UP = 16'h782E;
  localparam logic [PHY_DW-1:0] LPA_BASE       = 16'h4001;
  localparam logic [PHY_DW-1:0] LPA_ADV_MASK   = 16'h01E0;
  localparam logic [PHY_DW-1:0] SPEED_CONST    = 16'h8000;
  localparam int BASIC_SELF_CLR_BIT = 15;

  function automatic logic [PHY_DW-1:0] phy_reset_value(input int idx);
    case (idx)
      PREG_BASIC: return 16'h3100;
      PREG_ID_HI: return 16'h0300;
      PREG_ID_LO: return 16'hE400;
      PREG_ADV:   return 16'h01E1;
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
  import mdio_mgmt_pkg::*;
#(
  parameter int HOST_W = 32
) (
  input  logic [HOST_W-1:0] word,
  output mdio_cmd_t         cmd
);

  logic unused_bits;

  always_comb begin
    cmd.go    = word[CMD_GO_BIT];
    cmd.op    = word[CMD_OP_LSB +: 2];
    cmd.phy   = word[CMD_PHY_LSB +: PHY_AW];
    cmd.regad = word[CMD_REG_LSB +: REG_AW];
  end

  assign unused_bits = ^word;

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              op_err,
  output logic              div_err,
  output logic              phy_wr_en,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  input  logic [PHY_DW-1:0] phy_rdata
);

  localparam logic [HOST_W-1:0] RDY_MASK = HOST_W'(1) << CMD_RDY_BIT;

  logic [CTRL_W-1:0] ctrl_q;
  logic [HOST_W-1:0] cmd_q;
  logic [HOST_W-1:0] wdat_q;
  logic [HOST_W-1:0] rdat_q;
  logic [HOST_W-1:0] rd_mux;

  mdio_cmd_t cmd;
  logic      cmd_wr;
  logic      ctrl_wr;
  logic      load_rd;
  logic      bad_op;
  logic      zero_div;

  mdio_cmd_decode #(.HOST_W(HOST_W)) dec_i (
    .word (host_wdata),
    .cmd  (cmd)
  );

  assign cmd_wr   = host_wr && (host_sel_e'(host_sel) == SEL_CMD);
  assign ctrl_wr  = host_wr && (host_sel_e'(host_sel) == SEL_CTRL);
  assign load_rd  = cmd_wr && cmd.go && (cmd.op == OP_READ);
  assign bad_op   = cmd_wr && cmd.go && (cmd.op != OP_READ) && (cmd.op != OP_WRITE);
  assign zero_div = host_wdata[CTRL_EN_BIT] && (host_wdata[CTRL_DIV_W-1:0] == '0);

  assign phy_wr_en = cmd_wr && cmd.go && (cmd.op == OP_WRITE);
  assign phy_addr  = cmd.phy;
  assign reg_addr  = cmd.regad;
  assign phy_wdata = wdat_q[PHY_DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      op_err  <= 1'b0;
      div_err <= 1'b0;
    end else begin
      op_err  <= bad_op;
      div_err <= ctrl_wr && zero_div;
      if (host_wr) begin
        case (host_sel_e'(host_sel))
          SEL_CTRL: ctrl_q <= host_wdata[CTRL_W-1:0];
          SEL_CMD:  cmd_q  <= host_wdata;
          SEL_WDAT: wdat_q <= host_wdata;
          default:  rdat_q <= host_wdata;
        endcase
      end
      if (load_rd) begin
        rdat_q <= HOST_W'(phy_rdata);
      end
    end
  end

  always_comb begin
    case (host_sel_e'(host_sel))
      SEL_CTRL: rd_mux = HOST_W'(ctrl_q);
      SEL_CMD:  rd_mux = cmd_q | RDY_MASK;
      SEL_WDAT: rd_mux = wdat_q;
      default:  rd_mux = rdat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        host_rdata <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/mdio_phy_model.sv
module mdio_phy_model
  import mdio_mgmt_pkg::*;
#(
  parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [PHY_AW-1:0] req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic              wr_en,
  input  logic [PHY_DW-1:0] wr_data,
  output logic [PHY_DW-1:0] rd_data
);

  logic [PHY_DW-1:0] mem [PHY_NREG];
  logic [PHY_DW-1:0] adv;
  logic              hit;
  logic              fast_adv;
  logic              full_adv;
  logic [PHY_DW-1:0] diag_val;
  logic [PHY_DW-1:0] reg_val;

  assign hit = (req_phy == PHY_ADDR);
  assign adv = mem[PREG_ADV];

  // Speed and duplex summary derived from the advertisement register
  assign fast_adv = adv[7] | adv[8];
  assign full_adv = adv[6] | adv[8];

  always_comb begin
    diag_val = '0;
    if (link_up) begin
      diag_val[10] = fast_adv;
      diag_val[11] = full_adv;
    end
  end

  always_comb begin
    case (int'(req_reg))
      PREG_STATUS: reg_val = link_up ? STATUS_LINK_UP : '0;
      PREG_LPA:    reg_val = LPA_BASE | (adv & LPA_ADV_MASK);
      PREG_SPEED:  reg_val = SPEED_CONST;
      PREG_DIAG:   reg_val = diag_val;
      default:     reg_val = mem[req_reg];
    endcase
  end

  assign rd_data = hit ? reg_val : {PHY_DW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHY_NREG; i++) begin
        mem[i] <= phy_reset_value(i);
      end
    end else if (wr_en && hit) begin
      if (req_reg == REG_AW'(PREG_BASIC)) begin
        mem[PREG_BASIC] <= wr_data & ~(PHY_DW'(1) << BASIC_SELF_CLR_BIT);
      end else begin
        mem[req_reg] <= wr_data;
        mem[PREG_BASIC][BASIC_SELF_CLR_BIT] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_unit.sv
module mdio_mgmt_unit
  import mdio_mgmt_pkg::*;
#(
  parameter int                HOST_W   = 32,
  parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              link_up,
  output logic              op_err,
  output logic              div_err
);

  logic              phy_wr_en;
  logic [PHY_AW-1:0] phy_addr;
  logic [REG_AW-1:0] reg_addr;
  logic [PHY_DW-1:0] phy_wdata;
  logic [PHY_DW-1:0] phy_rdata;

  mdio_host_regs #(.HOST_W(HOST_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .op_err      (op_err),
    .div_err     (div_err),
    .phy_wr_en   (phy_wr_en),
    .phy_addr    (phy_addr),
    .reg_addr    (reg_addr),
    .phy_wdata   (phy_wdata),
    .phy_rdata   (phy_rdata)
  );

  mdio_phy_model #(.PHY_ADDR(PHY_ADDR)) phy_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .req_phy (phy_addr),
    .req_reg (reg_addr),
    .wr_en   (phy_wr_en),
    .wr_data (phy_wdata),
    .rd_data (phy_rdata)
  );

endmodule

// File: rtl/mdio_mgmt_unit_chk.sv
module mdio_mgmt_unit_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int HOST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_sel,
  input logic [HOST_W-1:0] host_wdata,
  input logic [HOST_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic              link_up,
  input logic              op_err,
  input logic              div_err
);

  logic unused_chk;
  assign unused_chk = link_up;

  // R4
  bad_op_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> $past(host_wr && host_sel == SEL_CMD && host_wdata[CMD_GO_BIT] &&
                     (host_wdata[CMD_OP_LSB +: 2] == 2'd0 || host_wdata[CMD_OP_LSB +: 2] == 2'd3)));

  // R7
  zero_div_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> $past(host_wr && host_sel == SEL_CTRL && host_wdata[CTRL_EN_BIT] &&
                      host_wdata[CTRL_DIV_W-1:0] == '0));

  // R6
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == SEL_CMD) |=> host_rdata[CMD_RDY_BIT]);

  // R7
  ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel == SEL_CTRL) |=> (host_rdata[HOST_W-1:CTRL_W] == '0));

  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R2
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);

endmodule

bind mdio_mgmt_unit mdio_mgmt_unit_chk #(.HOST_W(HOST_W)) chk_i (.*);

// File: tb/mdio_mgmt_unit_tb_top.sv
module mdio_mgmt_unit_tb_top;

  localparam logic [1:0] S_CTRL = 2'd0;
  localparam logic [1:0] S_CMD  = 2'd1;
  localparam logic [1:0] S_WDAT = 2'd2;
  localparam logic [1:0] S_RDAT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        link_up = 1'b1;
  logic        op_err;
  logic        div_err;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  mdio_mgmt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .link_up(link_up), .op_err(op_err), .div_err(div_err)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares returned read data in issue order
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check(host_rdata, 32'hDEAD_BEEF, "R2 unexpected rvalid");
      end else begin
        check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, input logic [31:0] exp, input string tag);
    host_rd = 1'b1; host_sel = s;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(input logic [4:0] pa, input logic [4:0] ra,
                                           input logic [1:0] op, input logic go);
    return {3'b0, pa, 3'b0, ra, op, 2'b0, go, 11'b0};
  endfunction

  task automatic phy_rd(input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] exp, input string tag);
    reg_write(S_CMD, cmd_word(pa, ra, 2'd2, 1'b1));
    reg_read(S_RDAT, {16'h0, exp}, tag);
  endtask

  task automatic phy_wr(input logic [4:0] pa, input logic [4:0] ra, input logic [31:0] d);
    reg_write(S_WDAT, d);
    reg_write(S_CMD, cmd_word(pa, ra, 2'd1, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(S_CTRL, 32'h0, "R1 ctrl reset");
    reg_read(S_CMD,  32'h80, "R1 cmd reset");
    reg_read(S_WDAT, 32'h0, "R1 wdat reset");
    reg_read(S_RDAT, 32'h0, "R1 rdat reset");
    phy_rd(5'd7, 5'd0, 16'h3100, "R1 phy reg0");
    phy_rd(5'd7, 5'd2, 16'h0300, "R1 phy reg2");
    phy_rd(5'd7, 5'd3, 16'hE400, "R1 phy reg3");
    phy_rd(5'd7, 5'd4, 16'h01E1, "R1 phy reg4");
    check({31'b0, op_err}, 32'h0, "R4 no error on valid read");

    // R2 stray bits in the command word are ignored
    reg_write(S_CMD, cmd_word(5'd7, 5'd2, 2'd2, 1'b1) | 32'hE0E0_3700);
    reg_read(S_RDAT, 32'h0000_0300, "R2 decode with stray bits");

    // R8 R9 R10 R11 with link up and reset advertisement
    phy_rd(5'd7, 5'd1,  16'h782E, "R8 status link up");
    phy_rd(5'd7, 5'd5,  16'h41E1, "R9 lpa reset adv");
    phy_rd(5'd7, 5'd17, 16'h8000, "R10 speed reg");
    phy_rd(5'd7, 5'd18, 16'h0C00, "R11 diag both");

    // R3 advertisement writes and derived values
    phy_wr(5'd7, 5'd4, 32'h0000_0041);
    phy_rd(5'd7, 5'd4,  16'h0041, "R3 adv write");
    phy_rd(5'd7, 5'd5,  16'h4041, "R9 lpa bit6");
    phy_rd(5'd7, 5'd18, 16'h0800, "R11 diag duplex only");
    phy_wr(5'd7, 5'd4, 32'h0000_0081);
    phy_rd(5'd7, 5'd5,  16'h4081, "R9 lpa bit7");
    phy_rd(5'd7, 5'd18, 16'h0400, "R11 diag speed only");
    phy_wr(5'd7, 5'd4, 32'h0000_0021);
    phy_rd(5'd7, 5'd18, 16'h0000, "R11 diag none");
    phy_wr(5'd7, 5'd4, 32'h0000_0181);

    // R8 R11 link down
    link_up = 1'b0;
    @(negedge clk);
    phy_rd(5'd7, 5'd1,  16'h0000, "R8 status link down");
    phy_rd(5'd7, 5'd18, 16'h0000, "R11 diag link down");
    phy_rd(5'd7, 5'd5,  16'h4181, "R9 lpa link down");
    link_up = 1'b1;
    @(negedge clk);
    phy_rd(5'd7, 5'd18, 16'h0C00, "R11 diag link back");

    // R12 self-clearing bit
    phy_wr(5'd7, 5'd0, 32'h0000_B100);
    phy_rd(5'd7, 5'd0, 16'h3100, "R12 reg0 bit15 clear");
    phy_wr(5'd7, 5'd0, 32'h0000_8000);
    phy_rd(5'd7, 5'd0, 16'h0000, "R12 reg0 only bit15");

    // R13 plain storage, R10 ignores writes
    phy_wr(5'd7, 5'd9, 32'h0000_1234);
    phy_rd(5'd7, 5'd9, 16'h1234, "R13 reg9 store");
    phy_wr(5'd7, 5'd31, 32'hABCD_5A5A);
    phy_rd(5'd7, 5'd31, 16'h5A5A, "R13 reg31 low half");
    phy_wr(5'd7, 5'd17, 32'h0000_1111);
    phy_rd(5'd7, 5'd17, 16'h8000, "R10 speed after write");

    // R5 absent PHY
    phy_rd(5'd3, 5'd0, 16'hFFFF, "R5 absent read");
    phy_wr(5'd3, 5'd9, 32'h0000_7777);
    phy_rd(5'd7, 5'd9, 16'h1234, "R5 absent write ignored");

    // R4 invalid opcodes and idle commands
    reg_write(S_WDAT, 32'h0000_4444);
    reg_write(S_CMD, cmd_word(5'd7, 5'd9, 2'd0, 1'b1));
    check({31'b0, op_err}, 32'h1, "R4 opcode 0 flagged");
    @(negedge clk);
    check({31'b0, op_err}, 32'h0, "R4 pulse one cycle");
    reg_write(S_CMD, cmd_word(5'd7, 5'd9, 2'd3, 1'b1));
    check({31'b0, op_err}, 32'h1, "R4 opcode 3 flagged");
    reg_read(S_RDAT, 32'h0000_1234, "R4 rdat unchanged");
    reg_write(S_CMD, cmd_word(5'd7, 5'd2, 2'd2, 1'b0));
    check({31'b0, op_err}, 32'h0, "R4 no start no error");
    reg_read(S_RDAT, 32'h0000_1234, "R4 no start no load");
    reg_write(S_CMD, cmd_word(5'd7, 5'd9, 2'd1, 1'b0));
    phy_rd(5'd7, 5'd9, 16'h1234, "R4 PHY unchanged");

    // R6 ready bit
    reg_write(S_CMD, 32'h0702_0000);
    reg_read(S_CMD, 32'h0702_0080, "R6 ready bit set");

    // R7 control register
    reg_write(S_CTRL, 32'hFFFF_FFC0);
    check({31'b0, div_err}, 32'h1, "R7 zero divisor flagged");
    reg_read(S_CTRL, 32'h0000_0040, "R7 ctrl masked");
    check({31'b0, div_err}, 32'h0, "R7 pulse one cycle");
    reg_write(S_CTRL, 32'h0000_0045);
    check({31'b0, div_err}, 32'h0, "R7 nonzero divisor ok");
    reg_read(S_CTRL, 32'h0000_0045, "R7 ctrl value");
    reg_write(S_CTRL, 32'h0000_0000);
    check({31'b0, div_err}, 32'h0, "R7 disabled no error");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "R2 missing read responses");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule